// File: doc/BRIEF.md
# Delta-Sigma Conversion Timing Sequencer

This block is the timing controller placed around the sinc decimation filter of a delta-sigma converter. It derives a modulator tick from the master clock, with one tick every 16 master clocks. It counts these ticks to decide when the filter output is settled. When a result is settled it raises a one-clock latch pulse for the filter's output register and drives an active-low data-ready strobe.

A conversion sequence begins on a rising edge of the start pin or on a decoded start-command pulse. The first result after a start, or after a channel change, has to wait for the filter flush, a fixed overhead and a programmable delay. In continuous mode, every later result follows exactly one conversion period after the one before. A change of the analog input alone does not restart anything. Only explicit start events and channel changes reset the count. The configuration inputs are captured when a sequence begins.

Top module: `dsm_conv_seq`

## Requirements
- R1: During and directly after reset, `drdy_no` is 1, `busy_o` is 0 and `latch_o` is 0. No conversion runs until a start event occurs.
- R2: A rising edge on `start_pin_i` or a one-cycle pulse on `start_cmd_i` starts a sequence, and `busy_o` is 1 after the next clock edge. A start pin that is held high does not start a second sequence.
- R3: The first result after a start appears as follows. `latch_o` is high in the cycle that follows the clock edge 16·T edges after the edge that sampled the start. T = S·P + OVH + DLY, where S = 3 when `sinc3_sel_i` = 1 and S = 1 when it is 0.
- R4: The conversion period P, in modulator periods, is set by `rate_code_i` as follows: code 0 gives 12800, 1 gives 5120, 2 gives 4264, 3 gives 2560, 4 gives 1280, 5 gives 640, 6 gives 320, 7 gives 256, 8 gives 128 and 9 gives 64. Codes 10 to 15 behave as code 9. OVH is 65 for codes 0 to 6 and 40 for all other codes.
- R5: DLY = 14 << `dly_code_i` modulator periods. It is added to the first result of a sequence only.
- R6: In continuous mode (`cont_mode_i` = 1), each later result follows the previous one by exactly 16·P clocks, and `busy_o` stays at 1.
- R7: In single-shot mode (`cont_mode_i` = 0), exactly one result is produced. `busy_o` falls on the same edge that raises `latch_o`, and no further result appears until a new start event.
- R8: `latch_o` is high for one clock per result. `drdy_no` goes low on the same edge and stays low for 16 clocks.
- R9: A start event or a `chan_chg_i` pulse during a conversion aborts the current count and restarts the first-result sequence from that edge. It also returns `drdy_no` high.
- R10: A `chan_chg_i` pulse while `busy_o` is 0 does not start a conversion and leaves all outputs unchanged.
- R11: `cont_mode_i`, `sinc3_sel_i`, `rate_code_i` and `dly_code_i` are sampled only on a start or restart edge. Changing them during a sequence does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_pin_i | input | 1 | Start pin; its rising edge begins a sequence |
| start_cmd_i | input | 1 | Decoded start-command pulse |
| chan_chg_i | input | 1 | Input-channel change pulse |
| cont_mode_i | input | 1 | 1 = continuous, 0 = single-shot |
| sinc3_sel_i | input | 1 | 1 = sinc3 filter, 0 = low-latency sinc1 |
| rate_code_i | input | 4 | Data-rate code |
| dly_code_i | input | 3 | Programmable first-result delay code |
| drdy_no | output | 1 | Active-low data-ready strobe |
| latch_o | output | 1 | One-clock result latch pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
Each stimulus is applied just after a falling clock edge, and the bench records the cycle number at that moment. The first result of the sequence is then due exactly 1 + 16·T cycles later, and each continuous follow-up is due 16·P cycles after the previous one. A driver pushes these cycle numbers into a queue. A monitor samples `latch_o` at every falling edge and matches it against the head of the queue. A pulse with no matching entry, or an entry whose cycle passes with no pulse, is a miscompare. The data-ready window is checked at 15 and 16 cycles after each matched pulse. Aborts, channel changes and ignored inputs are checked the same way, with the queue cleared and refilled from the new start edge.

// File: rtl/dsm_conv_seq.sv
module dsm_conv_seq #(
  parameter int MOD_DIV  = 16,
  parameter int CNT_W    = 18,
  parameter int DLY_BASE = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_pin_i,
  input  logic       start_cmd_i,
  input  logic       chan_chg_i,
  input  logic       cont_mode_i,
  input  logic       sinc3_sel_i,
  input  logic [3:0] rate_code_i,
  input  logic [2:0] dly_code_i,
  output logic       drdy_no,
  output logic       latch_o,
  output logic       busy_o
);
  localparam int PRE_W = $clog2(MOD_DIV);
  localparam int RDY_W = $clog2(MOD_DIV + 1);

  function automatic logic [CNT_W-1:0] period_mods(input logic [3:0] c);
    case (c)
      4'd0:    period_mods = CNT_W'(12800);
      4'd1:    period_mods = CNT_W'(5120);
      4'd2:    period_mods = CNT_W'(4264);
      4'd3:    period_mods = CNT_W'(2560);
      4'd4:    period_mods = CNT_W'(1280);
      4'd5:    period_mods = CNT_W'(640);
      4'd6:    period_mods = CNT_W'(320);
      4'd7:    period_mods = CNT_W'(256);
      4'd8:    period_mods = CNT_W'(128);
      default: period_mods = CNT_W'(64);
    endcase
  endfunction

  logic             start_q;
  logic             cont_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] mod_cnt, target, per_q;
  logic [RDY_W-1:0] rdy_cnt;

  wire start_rise = start_pin_i & ~start_q;
  wire restart    = start_rise | start_cmd_i | (chan_chg_i & busy_o);
  wire tick       = pre_cnt == PRE_W'(MOD_DIV - 1);
  wire done       = tick & (mod_cnt == target - CNT_W'(1));

  wire [CNT_W-1:0] per_in  = period_mods(rate_code_i);
  wire [CNT_W-1:0] ovh_in  = (rate_code_i <= 4'd6) ? CNT_W'(65) : CNT_W'(40);
  wire [CNT_W-1:0] dly_in  = CNT_W'(DLY_BASE) << dly_code_i;
  wire [CNT_W-1:0] flush   = sinc3_sel_i ? per_in * CNT_W'(3) : per_in;
  wire [CNT_W-1:0] first_t = flush + ovh_in + dly_in;

  assign drdy_no = rdy_cnt == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      cont_q  <= 1'b0;
      pre_cnt <= '0;
      mod_cnt <= '0;
      target  <= '0;
      per_q   <= '0;
      rdy_cnt <= '0;
      latch_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      start_q <= start_pin_i;
      latch_o <= 1'b0;
      if (rdy_cnt != '0) rdy_cnt <= rdy_cnt - RDY_W'(1);
      if (restart) begin
        busy_o  <= 1'b1;
        pre_cnt <= '0;
        mod_cnt <= '0;
        target  <= first_t;
        per_q   <= per_in;
        cont_q  <= cont_mode_i;
        rdy_cnt <= '0;
      end else if (busy_o) begin
        pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
        if (done) begin
          latch_o <= 1'b1;
          rdy_cnt <= RDY_W'(MOD_DIV);
          mod_cnt <= '0;
          target  <= per_q;
          busy_o  <= cont_q;
        end else if (tick) begin
          mod_cnt <= mod_cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

module dsm_conv_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_pin_i,
  input logic start_cmd_i,
  input logic chan_chg_i,
  input logic drdy_no,
  input logic latch_o,
  input logic busy_o,
  input logic cont_q
);
  p_cmd_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cmd_i |=> busy_o);
  p_cont_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o && cont_q |-> busy_o);
  p_single_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o && !cont_q |-> !busy_o);
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !latch_o);
  p_latch_drdy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !drdy_no);
  p_latch_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
  p_drdy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_no) && !start_cmd_i && !start_pin_i && !chan_chg_i |=> !drdy_no);
  p_restart_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cmd_i |=> drdy_no);
endmodule

bind dsm_conv_seq dsm_conv_seq_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_pin_i(start_pin_i),
  .start_cmd_i(start_cmd_i), .chan_chg_i(chan_chg_i), .drdy_no(drdy_no),
  .latch_o(latch_o), .busy_o(busy_o), .cont_q(cont_q)
);

// File: tb/dsm_conv_seq_tb_top.sv
module dsm_conv_seq_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start_pin = 1'b0, start_cmd = 1'b0, chan_chg = 1'b0;
  logic       cont_mode = 1'b0, sinc3 = 1'b1;
  logic [3:0] rate = 4'd9;
  logic [2:0] dly = 3'd0;
  logic       drdy_n, latch, busy;

  dsm_conv_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_pin_i(start_pin), .start_cmd_i(start_cmd),
    .chan_chg_i(chan_chg), .cont_mode_i(cont_mode), .sinc3_sel_i(sinc3),
    .rate_code_i(rate), .dly_code_i(dly), .drdy_no(drdy_n), .latch_o(latch), .busy_o(busy)
  );

  int    cyc = 0;
  int    nvec = 0, nbad = 0;
  int    exp_q[$];
  int    rdy_hi_at = -1;
  string cur_req = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: scoreboard side
  always @(negedge clk) if (rst_n) begin
    if (latch) begin
      if (exp_q.size() == 0) chk(0, "R7", "unexpected result cycle", cyc, -1);
      else begin
        chk(cyc == exp_q[0], cur_req, "result cycle", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
      chk(drdy_n == 1'b0, "R8", "drdy low with latch", drdy_n, 0);
      rdy_hi_at = cyc + 16;
    end else if (exp_q.size() != 0 && cyc > exp_q[0]) begin
      chk(0, cur_req, "missing result", cyc, exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (rdy_hi_at >= 0 && cyc == rdy_hi_at - 1) chk(drdy_n == 1'b0, "R8", "drdy still low at 15", drdy_n, 0);
    if (rdy_hi_at >= 0 && cyc == rdy_hi_at) begin
      chk(drdy_n == 1'b1, "R8", "drdy high at 16", drdy_n, 1);
      rdy_hi_at = -1;
    end
  end

  // driver side
  task automatic pulse_cmd(output int base);
    @(negedge clk); start_cmd = 1'b1; base = cyc; rdy_hi_at = -1;
    @(negedge clk); start_cmd = 1'b0;
  endtask

  task automatic pulse_chan(output int base);
    @(negedge clk); chan_chg = 1'b1; base = cyc; rdy_hi_at = -1;
    @(negedge clk); chan_chg = 1'b0;
  endtask

  task automatic push_expect(input int base, input int t, input int p, input int n, input string req);
    exp_q.delete();
    cur_req = req;
    for (int k = 0; k < n; k++) exp_q.push_back(base + 1 + 16 * t + 16 * p * k);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int b;
    repeat (4) @(negedge clk);
    chk(drdy_n == 1'b1, "R1", "drdy in reset", drdy_n, 1);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(latch == 1'b0, "R1", "latch in reset", latch, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy idle after reset", busy, 0);
    chk(drdy_n == 1'b1, "R1", "drdy idle after reset", drdy_n, 1);

    // single-shot sinc3, rate 9, delay code 0: T = 192+40+14
    pulse_cmd(b);
    chk(busy == 1'b1, "R2", "busy after command", busy, 1);
    push_expect(b, 246, 64, 1, "R3");
    drain();
    chk(busy == 1'b0, "R7", "busy after single result", busy, 0);
    repeat (1500) @(negedge clk);
    chk(busy == 1'b0, "R7", "busy stays low", busy, 0);

    // start pin edge, sinc1, rate 8, delay code 1: T = 128+40+28
    sinc3 = 1'b0; rate = 4'd8; dly = 3'd1;
    @(negedge clk); start_pin = 1'b1; b = cyc;
    push_expect(b, 196, 128, 1, "R5");
    @(negedge clk);
    chk(busy == 1'b1, "R2", "busy after pin edge", busy, 1);
    drain();
    repeat (2500) @(negedge clk);
    chk(busy == 1'b0, "R2", "held pin no restart", busy, 0);
    start_pin = 1'b0;

    // overhead 65 at rate 6: T = 320+65+14
    rate = 4'd6; dly = 3'd0;
    pulse_cmd(b);
    push_expect(b, 399, 320, 1, "R4");
    drain();

    // code 15 acts as 9: T = 64+40+14
    rate = 4'd15;
    pulse_cmd(b);
    push_expect(b, 118, 64, 1, "R4");
    drain();

    // abort by second command
    sinc3 = 1'b1; rate = 4'd9;
    pulse_cmd(b);
    push_expect(b, 246, 64, 1, "R9");
    repeat (1000) @(negedge clk);
    pulse_cmd(b);
    push_expect(b, 246, 64, 1, "R9");
    drain();

    // continuous, config changed mid-sequence
    cont_mode = 1'b1;
    pulse_cmd(b);
    push_expect(b, 246, 64, 2, "R6,R11");
    @(negedge clk);
    rate = 4'd7; dly = 3'd2; cont_mode = 1'b0; sinc3 = 1'b1;
    drain();
    chk(busy == 1'b1, "R11", "busy kept despite mode input", busy, 1);

    // channel change mid-run: T = 768+40+56, P = 256
    cont_mode = 1'b1;
    pulse_chan(b);
    push_expect(b, 864, 256, 2, "R9");
    @(negedge clk);
    chk(drdy_n == 1'b1, "R9", "drdy high after restart", drdy_n, 1);
    drain();
    chk(busy == 1'b1, "R6", "busy in continuous", busy, 1);

    // switch to single-shot by a command during continuous run
    cont_mode = 1'b0; sinc3 = 1'b0; rate = 4'd9; dly = 3'd0;
    pulse_cmd(b);
    push_expect(b, 118, 64, 1, "R7");
    drain();
    chk(busy == 1'b0, "R7", "busy after single", busy, 0);

    // channel change while idle
    pulse_chan(b);
    @(negedge clk);
    chk(busy == 1'b0, "R10", "idle channel change busy", busy, 0);
    repeat (3000) @(negedge clk);
    chk(busy == 1'b0, "R10", "idle channel change later", busy, 0);
    chk(drdy_n == 1'b1, "R10", "idle channel change drdy", drdy_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule